// File: doc/BRIEF.md
# Sideband Message Request Issuer

This block sits behind two 32-bit configuration-space registers and converts host writes into single requests on an internal sideband message network. The payload register (offset D4h) is loaded first, with the payload for messages that carry data. Writing the command register (offset D0h) then launches the request. The command word is unpacked into the message fields:

| Command bits | Field |
|---|---|
| 31:24 | opcode |
| 23:16 | destination port |
| 15:8 | target register offset |
| 7:4 | byte enables |

The payload register's contents at launch time travel with the message. Typical command words include a DRAM initialization command (opcode A0h), a DRAM base-ready notice (opcode B8h), and the fixed words 0201_00F0h (wake) and 4001_00F0h (FIFO clear).

Outgoing requests use a valid/ready channel. `msg_valid` rises the cycle after an accepted command write. All message fields stay frozen until a cycle in which `msg_ready` is high; the handshake completes on that edge. The target then answers on a response channel. The block asserts `rsp_ready` only while it waits for that answer, so a response offered at any other time is not consumed. A response flagged as carrying data overwrites the payload register, so the host can read the result back at D4h.

The `busy` output is a plain status pin. It is high from launch until the response handshake. A command write that arrives while `busy` is high is refused, and the sticky `err` pin is raised.

Top module: `sb_msg_issuer`

## Requirements
- R1: After reset, `msg_valid`, `busy`, `err` and `rsp_ready` are 0, and the payload register reads 0 at offset D4h.
- R2: The message fields are taken from the accepted command word: opcode from bits 31:24, port from bits 23:16, target offset from bits 15:8 and byte enables from bits 7:4. Bits 3:0 have no effect on any output.
- R3: A command write at D0h with all four host byte enables high, made while `busy` is low, raises `msg_valid` and `busy` in the next cycle. It produces exactly one message handshake.
- R4: `msg_data` equals the payload register value held before the command write. Payload writes made after the launch do not change the in-flight message.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field hold their values into the next cycle. `msg_valid` falls on the cycle after the handshake.
- R6: A command write with any host byte enable low is ignored: no message is sent, `busy` is not raised and `err` does not change.
- R7: `rsp_ready` is high only while `busy` is high and the message has been handed off. `busy` falls in the cycle after a response handshake.
- R8: A full command write while `busy` is high sends no new message and sets `err`. `err` stays set until the next accepted launch clears it.
- R9: A response handshake with `rsp_has_data` = 1 loads `rsp_data` into the payload register. With `rsp_has_data` = 0, the payload register is left unchanged.
- R10: A payload write at D4h updates only the bytes whose host byte enable is high. `host_rdata` returns the payload register when `host_addr` is D4h and returns 0 for any other address.
- R11: Writes to offsets other than D0h and D4h change no output. A response offered while `rsp_ready` is low is not consumed and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host register access strobe |
| host_we | input | 1 | Access is a write |
| host_addr | input | 8 | Configuration offset |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Payload register readback (0 unless the address is D4h) |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network accepts the message |
| msg_opcode | output | 8 | Message opcode |
| msg_port | output | 8 | Destination port |
| msg_offset | output | 8 | Target register offset |
| msg_be | output | 4 | Message byte enables |
| msg_data | output | 32 | Message payload |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_has_data | input | 1 | Response carries read data |
| rsp_data | input | 32 | Returned read data |
| busy | output | 1 | Request outstanding |
| err | output | 1 | Sticky refused-command flag |

## Verification
Requests are launched under several target behaviours:
- A target that accepts at once tells a correct handoff apart from one that is delayed or doubled.
- A target that stalls for several cycles while the host rewrites the payload and retries the command separates a latched payload from a live one, and a refused command from a queued one.
- Responses with and without data, plus a response offered while idle, show whether capture is gated by the handshake and the data flag.
- Partial byte enables on both registers, nonzero reserved bits and a write to a foreign offset show that only full command writes launch and that payload bytes merge lane by lane.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int OPC_W = 8;
  localparam int PORT_W = 8;
  localparam int OFS_W = 8;
  localparam int MBE_W = 4;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [PORT_W-1:0] port;
    logic [OFS_W-1:0]  offset;
    logic [MBE_W-1:0]  be;
  } sbm_hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } sbm_state_e;

  function automatic sbm_hdr_t unpack_cmd(input logic [31:0] w);
    sbm_hdr_t h;
    h.opcode = w[31:24];
    h.port   = w[23:16];
    h.offset = w[15:8];
    h.be     = w[7:4];
    return h;
  endfunction
endpackage

// File: rtl/sbm_host_regs.sv
module sbm_host_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'hD0,
  parameter logic [ADDR_W-1:0] PAY_OFS = 8'hD4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W/8-1:0] host_be,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic                cap_en,
  input  logic [DATA_W-1:0]   cap_data,
  output logic                cmd_wr,
  output logic [DATA_W-1:0]   pay_q,
  output logic [DATA_W-1:0]   host_rdata
);
  localparam int NB = DATA_W / 8;

  logic pay_wr;

  assign cmd_wr = host_req && host_we && (host_addr == CMD_OFS) && (&host_be);
  assign pay_wr = host_req && host_we && (host_addr == PAY_OFS);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pay_q[8*b +: 8] <= '0;
      end else if (cap_en) begin
        pay_q[8*b +: 8] <= cap_data[8*b +: 8];
      end else if (pay_wr && host_be[b]) begin
        pay_q[8*b +: 8] <= host_wdata[8*b +: 8];
      end
    end
  end

  assign host_rdata = (host_addr == PAY_OFS) ? pay_q : '0;
endmodule

// File: rtl/sbm_launch_ctl.sv
module sbm_launch_ctl
  import sbm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic [DATA_W-1:0] pay_q,
  input  logic              msg_ready,
  input  logic              rsp_valid,
  output logic              msg_valid,
  output sbm_hdr_t          hdr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              rsp_ready,
  output logic              rsp_fire,
  output logic              busy,
  output logic              err
);
  sbm_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      err    <= 1'b0;
      hdr_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_wr) begin
          hdr_q  <= unpack_cmd(cmd_word);
          data_q <= pay_q;
          err    <= 1'b0;
          state  <= ST_SEND;
        end
        ST_SEND: begin
          if (cmd_wr) err <= 1'b1;
          if (msg_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cmd_wr) err <= 1'b1;
          if (rsp_valid) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid = (state == ST_SEND);
  assign rsp_ready = (state == ST_WAIT);
  assign rsp_fire  = rsp_ready && rsp_valid;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/sb_msg_issuer.sv
module sb_msg_issuer
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'hD0,
  parameter logic [ADDR_W-1:0] PAY_OFS = 8'hD4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W/8-1:0] host_be,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [OPC_W-1:0]    msg_opcode,
  output logic [PORT_W-1:0]   msg_port,
  output logic [OFS_W-1:0]    msg_offset,
  output logic [MBE_W-1:0]    msg_be,
  output logic [DATA_W-1:0]   msg_data,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic                rsp_has_data,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                busy,
  output logic                err
);
  logic              cmd_wr;
  logic              rsp_fire;
  logic [DATA_W-1:0] pay_q;
  sbm_hdr_t          hdr_q;

  sbm_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFS(CMD_OFS), .PAY_OFS(PAY_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata),
    .cap_en(rsp_fire && rsp_has_data), .cap_data(rsp_data),
    .cmd_wr(cmd_wr), .pay_q(pay_q), .host_rdata(host_rdata)
  );

  sbm_launch_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_word(host_wdata[31:0]), .pay_q(pay_q),
    .msg_ready(msg_ready), .rsp_valid(rsp_valid),
    .msg_valid(msg_valid), .hdr_q(hdr_q), .data_q(msg_data),
    .rsp_ready(rsp_ready), .rsp_fire(rsp_fire), .busy(busy), .err(err)
  );

  assign msg_opcode = hdr_q.opcode;
  assign msg_port   = hdr_q.port;
  assign msg_offset = hdr_q.offset;
  assign msg_be     = hdr_q.be;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'hD0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_req,
  input logic                host_we,
  input logic [ADDR_W-1:0]   host_addr,
  input logic [DATA_W/8-1:0] host_be,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_opcode,
  input logic [7:0]          msg_port,
  input logic [7:0]          msg_offset,
  input logic [3:0]          msg_be,
  input logic [DATA_W-1:0]   msg_data,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                busy,
  input logic                err
);
  logic cmd_any;
  assign cmd_any = host_req && host_we && (host_addr == CMD_OFS);

  // R5: stalled message keeps every field
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_opcode) && $stable(msg_port)
      && $stable(msg_offset) && $stable(msg_be) && $stable(msg_data));

  // R5: handshake ends the valid phase
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R3: accepted command launches
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_any && (&host_be) |=> msg_valid && busy);

  // R6: partial command write does nothing
  a_r6_partial: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_any && !(&host_be) |=> !msg_valid && !busy && $stable(err));

  // R7: response acceptance only after handoff
  a_r7_rsp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !msg_valid);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready && rsp_valid |=> !busy);

  // R8: refused command raises the error flag
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_any && (&host_be) |=> err);

  // R7: valid implies busy
  a_r7_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> busy);
endmodule

bind sb_msg_issuer sbm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFS(CMD_OFS)
) u_sbm_checker (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_be(host_be), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_opcode(msg_opcode), .msg_port(msg_port),
  .msg_offset(msg_offset), .msg_be(msg_be), .msg_data(msg_data),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .busy(busy), .err(err)
);

// File: tb/tb_sb_msg_issuer.sv
module tb_sb_msg_issuer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [3:0]  host_be = 4'h0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_opcode, msg_port, msg_offset;
  logic [3:0]  msg_be;
  logic [31:0] msg_data;
  logic        rsp_valid = 1'b0, rsp_ready, rsp_has_data = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        busy, err;

  always #4 clk = ~clk;

  sb_msg_issuer dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_opcode(msg_opcode), .msg_port(msg_port), .msg_offset(msg_offset),
    .msg_be(msg_be), .msg_data(msg_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_has_data(rsp_has_data), .rsp_data(rsp_data),
    .busy(busy), .err(err)
  );

  int errors = 0, checks = 0;
  int launches = 0, handshakes = 0;

  // behavioural reference state
  bit        m_valid, m_busy, m_err;
  bit [31:0] m_pay, m_cmd, m_data;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_step();
    bit cmd_full, pay_wr, hs_m, hs_r;
    cmd_full = host_req && host_we && host_addr == 8'hD0 && host_be == 4'hF;
    pay_wr   = host_req && host_we && host_addr == 8'hD4;
    hs_m     = m_valid && msg_ready;
    hs_r     = m_busy && !m_valid && rsp_valid;
    if (msg_valid && msg_ready) handshakes++;
    if (hs_m) m_valid = 0;
    if (cmd_full) begin
      if (m_busy) m_err = 1;
      else begin
        m_valid = 1; m_busy = 1; m_err = 0;
        m_cmd = host_wdata; m_data = m_pay; launches++;
      end
    end
    if (hs_r) begin
      m_busy = 0;
      if (rsp_has_data) m_pay = rsp_data;
    end else if (pay_wr) begin
      for (int b = 0; b < 4; b++)
        if (host_be[b]) m_pay[8*b +: 8] = host_wdata[8*b +: 8];
    end
  endtask

  task automatic compare();
    chk("R3 msg_valid", msg_valid, m_valid);
    chk("R7 busy", busy, m_busy);
    chk("R7 rsp_ready", rsp_ready, m_busy && !m_valid);
    chk("R8 err", err, m_err);
    chk("R10 host_rdata", host_rdata, host_addr == 8'hD4 ? m_pay : 32'h0);
    if (m_valid) begin
      chk("R2 opcode", msg_opcode, m_cmd[31:24]);
      chk("R2 port", msg_port, m_cmd[23:16]);
      chk("R2 offset", msg_offset, m_cmd[15:8]);
      chk("R2 be", msg_be, m_cmd[7:4]);
      chk("R4 payload", msg_data, m_data);
    end
  endtask

  // one clock: model sees the inputs just before the edge, compare after it
  task automatic cyc();
    #1;
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    host_req = 1; host_we = 1; host_addr = a; host_be = be; host_wdata = d;
    cyc();
    host_req = 0; host_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    host_addr = 8'hD4;
    idle(1);
    // R1 reset state
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 rsp_ready", rsp_ready, 0);
    chk("R1 payload", host_rdata, 32'h0);

    // R10 full payload write, then R2/R4/R5 stalled launch with reserved bits set
    wr(8'hD4, 4'hF, 32'h1234_5678);
    host_addr = 8'hD4; idle(1);
    chk("R10 payload readback", host_rdata, 32'h1234_5678);
    wr(8'hD0, 4'hF, 32'hA001_03F5);
    chk("R3 launched", msg_valid, 1);
    chk("R2 opcode A0", msg_opcode, 8'hA0);
    chk("R2 port 01", msg_port, 8'h01);
    chk("R2 offset 03", msg_offset, 8'h03);
    chk("R2 be F", msg_be, 4'hF);
    idle(2);
    wr(8'hD4, 4'hF, 32'hFFFF_FFFF);         // R4 payload rewrite during flight
    chk("R4 in-flight payload kept", msg_data, 32'h1234_5678);
    wr(8'hD0, 4'hF, 32'hB804_0000);         // R8 refused
    chk("R8 err set", err, 1);
    chk("R5 still valid", msg_valid, 1);
    msg_ready = 1; idle(1); msg_ready = 0;
    chk("R5 valid dropped", msg_valid, 0);
    chk("R7 waiting", rsp_ready, 1);
    idle(2);
    rsp_valid = 1; rsp_has_data = 0; rsp_data = 32'hDEAD_BEEF;
    idle(1); rsp_valid = 0;
    host_addr = 8'hD4; idle(1);
    chk("R7 busy released", busy, 0);
    chk("R9 no-data response keeps payload", host_rdata, 32'hFFFF_FFFF);

    // R6 partial command write
    wr(8'hD0, 4'b0111, 32'hA001_03F0);
    chk("R6 no launch", msg_valid, 0);
    chk("R6 err unchanged", err, 1);
    idle(1);

    // wake word with an eager target and a data response
    msg_ready = 1;
    wr(8'hD0, 4'hF, 32'h0201_00F0);
    chk("R8 err cleared by launch", err, 0);
    chk("R2 wake opcode", msg_opcode, 8'h02);
    idle(1); msg_ready = 0;
    rsp_valid = 1; rsp_has_data = 1; rsp_data = 32'hCAFE_F00D;
    idle(1); rsp_valid = 0; rsp_has_data = 0;
    host_addr = 8'hD4; idle(1);
    chk("R9 data captured", host_rdata, 32'hCAFE_F00D);

    // R10 lane merge, R11 foreign offset, stray response
    wr(8'hD4, 4'b0101, 32'h1122_3344);
    host_addr = 8'hD4; idle(1);
    chk("R10 lane merge", host_rdata, 32'hCA22_F044);
    wr(8'hD8, 4'hF, 32'h0);
    host_addr = 8'hD4; idle(1);
    chk("R11 foreign write", host_rdata, 32'hCA22_F044);
    chk("R11 no launch", msg_valid, 0);
    host_addr = 8'hD0; idle(1);
    chk("R10 other address reads 0", host_rdata, 32'h0);
    rsp_valid = 1; rsp_has_data = 1; rsp_data = 32'h0;
    idle(2); rsp_valid = 0; rsp_has_data = 0;
    host_addr = 8'hD4; idle(1);
    chk("R11 stray response ignored", host_rdata, 32'hCA22_F044);

    // clear-FIFO word then a base-ready payload message
    msg_ready = 1;
    wr(8'hD0, 4'hF, 32'h4001_00F0);
    idle(1); msg_ready = 0;
    rsp_valid = 1; idle(1); rsp_valid = 0;
    wr(8'hD4, 4'hF, 32'h1FF0_0000);
    wr(8'hD0, 4'hF, 32'hB804_00F0);
    chk("R4 base-ready payload", msg_data, 32'h1FF0_0000);
    idle(1); msg_ready = 1; idle(1); msg_ready = 0;
    rsp_valid = 1; idle(1); rsp_valid = 0;
    idle(2);
    chk("R3 one handshake per launch", handshakes, launches);
    chk("R3 launch count", launches, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule